// File: doc/BRIEF.md
# Traffic-Class Virtual-Channel Transmit Scheduler

This block queues outgoing packet descriptors by priority class before they go to a single transmit output. Each descriptor arrives with a payload word and a 3-bit class label (0 to 7). A small programmable table translates the class into a channel index. The descriptor is then stored in that channel's own in-order FIFO. On the output side, a strict-priority selector picks the highest-numbered channel that holds data. As a result, a later packet of a high class can leave before an earlier backlog of low-class packets that sits in a different channel.

Both edges use a valid/ready handshake. The input stalls only when the FIFO its class maps to is full. The output presents the payload together with the channel index it came from. Software changes the class-to-channel table through a one-cycle write strobe. Descriptors that are already queued never move between channels.

Top module: `tc_vc_scheduler`

## Requirements
- R1: After reset, `out_valid` is low, `in_ready` is high, and the table maps class c to channel c/2, so classes 0-1 go to 0, 2-3 to 1, 4-5 to 2 and 6-7 to 3.
- R2: An accepted descriptor is later presented with `out_chan` equal to the table entry for its class, and with its payload unchanged.
- R3: Descriptors of one channel leave in the order they were accepted.
- R4: If the previous cycle was not a stall, the selected channel is the highest-indexed non-empty one. A high-class descriptor accepted later therefore overtakes queued lower-channel descriptors.
- R5: `in_ready` is low exactly when the channel that `in_class` maps to holds 8 descriptors. A full channel does not lower `in_ready` for a class that maps elsewhere.
- R6: While `out_valid` is high and `out_ready` is low, `out_chan` and `out_payload` hold in the next cycle, even if a higher channel receives data.
- R7: A table write (`map_we` high with `map_class` and `map_chan`) applies to descriptors accepted in later cycles. Descriptors that are already queued stay in their channel.
- R8: A transfer happens when `out_valid` and `out_ready` are both high, and it removes exactly one descriptor. A descriptor accepted at a clock edge is visible on the output after that edge.
- R9: Each channel stores up to 8 descriptors. No channel ever holds more than 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Target channel has room |
| in_payload | input | PAYLOAD_W | Descriptor payload |
| in_class | input | 3 | Traffic class label |
| map_we | input | 1 | Table write strobe |
| map_class | input | 3 | Table entry to write |
| map_chan | input | 2 | Channel index to store |
| out_valid | output | 1 | Some channel is non-empty |
| out_ready | input | 1 | Sink accepts this cycle |
| out_payload | output | PAYLOAD_W | Selected descriptor payload |
| out_chan | output | 2 | Channel the payload came from |

## Verification
The first pattern offers one descriptor of every class while the output is stalled. The drain order that follows separates the default mapping and the priority order, and it also shows that the channel locked at stall time is kept. The second pattern accepts a class-7 descriptor in the same cycle that a class-0 descriptor leaves. This tells true overtaking apart from a FIFO-wide ordering. The third pattern fills one channel to 8 and then offers a class that maps elsewhere, which separates per-channel backpressure from a global one. The last pattern reprograms a class between two accepts and shows where each of the two descriptors ends up.

// File: rtl/tc_vc_scheduler.sv
module tc_vc_scheduler #(
  parameter int PAYLOAD_W = 32,
  parameter int NUM_CH    = 4,
  parameter int DEPTH     = 8,
  parameter int CLASS_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [PAYLOAD_W-1:0]          in_payload,
  input  logic [CLASS_W-1:0]            in_class,
  input  logic                          map_we,
  input  logic [CLASS_W-1:0]            map_class,
  input  logic [$clog2(NUM_CH)-1:0]     map_chan,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [PAYLOAD_W-1:0]          out_payload,
  output logic [$clog2(NUM_CH)-1:0]     out_chan
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int CNT_W  = PTR_W + 1;
  localparam int NUM_TC = 1 << CLASS_W;

  logic [CH_W-1:0]                    map_q [NUM_TC];
  logic [NUM_CH-1:0][CNT_W-1:0]       occ;
  logic [NUM_CH-1:0][PAYLOAD_W-1:0]   head;
  logic [NUM_CH-1:0]                  busy;
  logic [CH_W-1:0]                    tgt, pick, sel, hold_ch_q;
  logic                               hold_q;

  wire push = in_valid && in_ready;
  wire pop  = out_valid && out_ready;

  assign tgt      = map_q[in_class];
  assign in_ready = occ[tgt] != CNT_W'(DEPTH);

  always_comb begin
    pick = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (busy[c]) pick = CH_W'(c);
  end

  assign sel         = hold_q ? hold_ch_q : pick;
  assign out_valid   = |busy;
  assign out_chan    = sel;
  assign out_payload = head[sel];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NUM_TC; t++) map_q[t] <= CH_W'((t * NUM_CH) / NUM_TC);
      hold_q    <= 1'b0;
      hold_ch_q <= '0;
    end else begin
      if (map_we) map_q[map_class] <= map_chan;
      hold_q    <= out_valid && !out_ready;
      hold_ch_q <= sel;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [PAYLOAD_W-1:0] fifo_q [DEPTH];
    logic [PTR_W-1:0]     wr_q, rd_q;
    logic [CNT_W-1:0]     cnt_q;
    wire do_push = push && (tgt == CH_W'(c));
    wire do_pop  = pop && (sel == CH_W'(c));

    assign occ[c]  = cnt_q;
    assign busy[c] = cnt_q != '0;
    assign head[c] = fifo_q[rd_q];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wr_q  <= '0;
        rd_q  <= '0;
        cnt_q <= '0;
      end else begin
        if (do_push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
        if (do_pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
        if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
        else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
      end
    end

    always_ff @(posedge clk)
      if (do_push) fifo_q[wr_q] <= in_payload;
  end
endmodule

// File: rtl/tc_vc_scheduler_checks.sv
module tc_vc_scheduler_checks #(
  parameter int PAYLOAD_W = 32,
  parameter int NUM_CH    = 4,
  parameter int DEPTH     = 8,
  parameter int CNT_W     = 4,
  parameter int CH_W      = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         out_valid,
  input logic                         out_ready,
  input logic [PAYLOAD_W-1:0]         out_payload,
  input logic [CH_W-1:0]              out_chan,
  input logic [NUM_CH-1:0][CNT_W-1:0] occ
);
  logic over, higher_busy;
  always_comb begin
    over = 1'b0;
    higher_busy = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (occ[c] > CNT_W'(DEPTH)) over = 1'b1;
      if (c > int'(out_chan) && occ[c] != '0) higher_busy = 1'b1;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n) !over);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !out_valid);
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chan) && $stable(out_payload));
  p_valid_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> occ[out_chan] != '0);
  p_strict_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(rst_n) && !$past(out_valid && !out_ready) |-> !higher_busy);
endmodule

bind tc_vc_scheduler tc_vc_scheduler_checks #(
  .PAYLOAD_W(PAYLOAD_W), .NUM_CH(NUM_CH), .DEPTH(DEPTH), .CNT_W(CNT_W), .CH_W(CH_W)
) u_checks (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_payload(out_payload), .out_chan(out_chan), .occ(occ)
);

// File: tb/tc_vc_scheduler_bench.sv
module tc_vc_scheduler_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, map_we = 1'b0, out_ready = 1'b0;
  logic [31:0] in_payload = '0;
  logic [2:0] in_class = '0, map_class = '0;
  logic [1:0] map_chan = '0;
  logic in_ready, out_valid;
  logic [31:0] out_payload;
  logic [1:0] out_chan;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  tc_vc_scheduler u_tc_vc_scheduler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_payload(in_payload), .in_class(in_class), .map_we(map_we),
    .map_class(map_class), .map_chan(map_chan), .out_valid(out_valid),
    .out_ready(out_ready), .out_payload(out_payload), .out_chan(out_chan)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] p, input logic [2:0] cls, output bit acc);
    @(negedge clk);
    in_valid = 1'b1; in_payload = p; in_class = cls;
    #1 acc = in_ready;
    @(posedge clk); #1 in_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [31:0] p, input logic [1:0] ch, input string tag);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    chk(out_valid === 1'b1, {tag, " valid"}, 32'(out_valid), 1);
    chk(out_chan === ch, {tag, " chan"}, 32'(out_chan), 32'(ch));
    chk(out_payload === p, {tag, " payload"}, out_payload, p);
    @(posedge clk); #1 out_ready = 1'b0;
  endtask

  task automatic write_map(input logic [2:0] cls, input logic [1:0] ch);
    @(negedge clk);
    map_we = 1'b1; map_class = cls; map_chan = ch;
    @(posedge clk); #1 map_we = 1'b0;
  endtask

  task automatic t_reset_and_map();
    bit acc;
    chk(out_valid === 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
    chk(in_ready === 1'b1, "R1 in_ready after reset", 32'(in_ready), 1);
    for (int c = 0; c < 8; c++) begin
      push(32'h100 + 32'(c), 3'(c), acc);
      chk(acc, "R2 accept", 32'(acc), 1);
      if (c == 0) chk(out_valid === 1'b1, "R8 visible after accept", 32'(out_valid), 1);
    end
    pop_expect(32'h100, 2'd0, "R6 locked ch0 first");
    pop_expect(32'h106, 2'd3, "R4 R1 class6");
    pop_expect(32'h107, 2'd3, "R3 class7");
    pop_expect(32'h104, 2'd2, "R4 R1 class4");
    pop_expect(32'h105, 2'd2, "R3 class5");
    pop_expect(32'h102, 2'd1, "R4 R1 class2");
    pop_expect(32'h103, 2'd1, "R3 class3");
    pop_expect(32'h101, 2'd0, "R2 class1");
    #1 chk(out_valid === 1'b0, "R8 empty after drain", 32'(out_valid), 0);
  endtask

  task automatic t_overtake();
    bit acc;
    push(32'hA0, 3'd0, acc);
    push(32'hA1, 3'd0, acc);
    push(32'hA2, 3'd0, acc);
    @(negedge clk);
    out_ready = 1'b1; in_valid = 1'b1; in_payload = 32'hD7; in_class = 3'd7;
    #1 chk(out_chan === 2'd0 && out_payload === 32'hA0, "R4 head before overtake", out_payload, 32'hA0);
    @(posedge clk); #1 in_valid = 1'b0; out_ready = 1'b0;
    pop_expect(32'hD7, 2'd3, "R4 overtake");
    pop_expect(32'hA1, 2'd0, "R3 order kept");
    pop_expect(32'hA2, 2'd0, "R3 order kept 2");
  endtask

  task automatic t_full();
    bit acc;
    for (int i = 0; i < 8; i++) begin
      push(32'h200 + 32'(i), 3'd2, acc);
      chk(acc, "R9 accept up to 8", 32'(acc), 1);
    end
    push(32'h2FF, 3'd3, acc);
    chk(!acc, "R5 full channel blocks", 32'(acc), 0);
    @(negedge clk);
    in_class = 3'd0;
    #1 chk(in_ready === 1'b1, "R5 other channel ready", 32'(in_ready), 1);
    in_class = 3'd5;
    #1 chk(in_ready === 1'b1, "R5 other channel ready 2", 32'(in_ready), 1);
    for (int i = 0; i < 8; i++) pop_expect(32'h200 + 32'(i), 2'd1, "R3 R9 drain");
    #1 chk(out_valid === 1'b0, "R5 rejected not stored", 32'(out_valid), 0);
  endtask

  task automatic t_stall();
    bit acc;
    push(32'h51, 3'd1, acc);
    push(32'h57, 3'd7, acc);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_chan === 2'd0 && out_payload === 32'h51, "R6 hold under stall", out_payload, 32'h51);
    end
    pop_expect(32'h51, 2'd0, "R6 held item leaves");
    pop_expect(32'h57, 2'd3, "R8 next item");
    #1 chk(out_valid === 1'b0, "R8 single pop each", 32'(out_valid), 0);
  endtask

  task automatic t_remap();
    bit acc;
    push(32'h61, 3'd1, acc);
    write_map(3'd1, 2'd3);
    push(32'h62, 3'd1, acc);
    pop_expect(32'h61, 2'd0, "R7 queued stays");
    pop_expect(32'h62, 2'd3, "R7 new mapping");
    write_map(3'd1, 2'd0);
    push(32'h63, 3'd1, acc);
    pop_expect(32'h63, 2'd0, "R7 restored mapping");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset_and_map();
    t_overtake();
    t_full();
    t_stall();
    t_remap();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule